// File: doc/BRIEF.md
# Pipelined Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor, and both can change on every clock. A typical use is scaling a fast sample stream, such as the output of a frequency synthesizer, by a value that software or other logic sets at run time. The divisor may be any value. It is not limited to a constant or a power of two.

The long-division loop is unrolled into a chain of registered stages. Each stage resolves a parameter-set number of quotient bits with add-or-subtract steps. At each step the sign of the running partial remainder picks whether the divisor is added or subtracted, so no step ever compares first and then passes the value through. Each quotient bit is the inverted sign of the partial remainder that step produced. A final correction adds the divisor back once when the last partial remainder is negative.

The divisor and the valid flag travel through the stages with the data. The block therefore accepts a new operand pair on every clock and returns one result per clock after a fixed latency. Division by zero raises no flag and gives a defined result.

Top module: `nr_div`

## Requirements
- R1: For a nonzero divisor, a result returned with out_valid high has quotient = floor(dividend / divisor) and remainder = dividend mod divisor, both W bits wide.
- R2: The latency is ceil(W / BPS) + OUT_REG clocks, which is 5 with the defaults. out_valid is high exactly that many clocks after in_valid was sampled high and is low otherwise, so gaps in the input stream reappear unchanged at the output.
- R3: Operand pairs presented on consecutive clocks are each divided independently. A divisor or dividend from one cycle never affects the result of another cycle.
- R4: A divisor of zero returns a quotient with all bits set and a remainder equal to the dividend.
- R5: For a nonzero divisor the remainder is always below the divisor, and the partial remainder leaving the last stage lies in the range [-divisor, divisor).
- R6: rst is synchronous and active high. It clears every in-flight valid flag, so out_valid is low on the clock after rst is sampled and stays low until a pair presented after reset reaches the end of the pipeline.
- R7: Extreme operands give exact results: an all-ones dividend divided by 1 or by itself, a zero dividend, and a divisor larger than the dividend (which must return quotient 0 and remainder equal to the dividend).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on dividend/divisor is valid this cycle |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| out_valid | output | 1 | quotient/remainder hold a result |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |

## Verification
The bench targets results that end on a negative partial remainder. A design that skips the final add-back would return a remainder that has wrapped around and is at least the divisor. Divisors larger than the dividend, and divisors of one and of all ones, test the carry at the top of the partial remainder; a partial remainder one bit too narrow would corrupt those quotients. Back-to-back pairs with different divisors, valid patterns with gaps, and a reset issued while data is in flight show whether the divisor and the valid flag stay aligned with their own data, and whether stale results leak out after reset. A zero divisor checks the defined all-ones quotient.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/nr_div_stage.sv
// One registered stage: NB add-or-subtract steps, then a register.
// rem is a (W+2)-bit two's complement partial remainder.
// qd holds unused dividend bits at the top and shifts quotient bits in at the bottom.
module nr_div_stage #(
  parameter int W  = 16,
  parameter int NB = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W+1:0] in_rem,
  input  logic [W-1:0] in_qd,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W+1:0] out_rem,
  output logic [W-1:0] out_qd,
  output logic [W-1:0] out_d
);
  logic [W+1:0] r_nx;
  logic [W-1:0] qd_nx;

  always_comb begin
    r_nx  = in_rem;
    qd_nx = in_qd;
    for (int k = 0; k < NB; k++) begin
      if (!r_nx[W+1]) r_nx = {r_nx[W:0], qd_nx[W-1]} - {2'b00, in_d};
      else            r_nx = {r_nx[W:0], qd_nx[W-1]} + {2'b00, in_d};
      qd_nx = {qd_nx[W-2:0], ~r_nx[W+1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_v <= 1'b0;
    else     out_v <= in_v;
  end

  always_ff @(posedge clk) begin
    out_rem <= r_nx;
    out_qd  <= qd_nx;
    out_d   <= in_d;
  end
endmodule

// File: rtl/nr_div_fix.sv
// Remainder correction and optional output register.
module nr_div_fix #(
  parameter int W       = 16,
  parameter int OUT_REG = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W+1:0] in_rem,
  input  logic [W-1:0] in_q,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_q,
  output logic [W-1:0] out_r,
  output logic [W-1:0] out_d
);
  logic [W-1:0] r_fix;

  // The true remainder lies in [0, d), so W-bit arithmetic is exact.
  assign r_fix = in_rem[W-1:0] + (in_rem[W+1] ? in_d : '0);

  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) out_v <= 1'b0;
      else     out_v <= in_v;
    end
    always_ff @(posedge clk) begin
      out_q <= in_q;
      out_r <= r_fix;
      out_d <= in_d;
    end
  end else begin : g_comb
    assign out_v = in_v;
    assign out_q = in_q;
    assign out_r = r_fix;
    assign out_d = in_d;
  end
endmodule

// File: rtl/nr_div.sv
module nr_div #(
  parameter int W       = 16,
  parameter int BPS     = 4,
  parameter int OUT_REG = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         out_valid,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  import nr_div_pkg::*;

  localparam int NST = ceil_div(W, BPS);
  localparam int LAT = NST + ((OUT_REG != 0) ? 1 : 0);
  localparam int LASTNB = W - BPS * (NST - 1);

  logic [NST:0]          v_p;
  logic [NST:0][W+1:0]   rem_p;
  logic [NST:0][W-1:0]   qd_p;
  logic [NST:0][W-1:0]   d_p;
  logic [W-1:0]          fin_div;

  assign v_p[0]   = in_valid;
  assign rem_p[0] = '0;
  assign qd_p[0]  = dividend;
  assign d_p[0]   = divisor;

  for (genvar s = 0; s < NST; s++) begin : g_st
    localparam int NB = (s == NST - 1) ? LASTNB : BPS;
    nr_div_stage #(.W(W), .NB(NB)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .in_v   (v_p[s]),
      .in_rem (rem_p[s]),
      .in_qd  (qd_p[s]),
      .in_d   (d_p[s]),
      .out_v  (v_p[s+1]),
      .out_rem(rem_p[s+1]),
      .out_qd (qd_p[s+1]),
      .out_d  (d_p[s+1])
    );
  end

  nr_div_fix #(.W(W), .OUT_REG(OUT_REG)) u_fix (
    .clk   (clk),
    .rst   (rst),
    .in_v  (v_p[NST]),
    .in_rem(rem_p[NST]),
    .in_q  (qd_p[NST]),
    .in_d  (d_p[NST]),
    .out_v (out_valid),
    .out_q (quotient),
    .out_r (remainder),
    .out_d (fin_div)
  );
endmodule

// File: rtl/nr_div_chk.sv
module nr_div_chk #(
  parameter int W   = 16,
  parameter int LAT = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic [W-1:0] fin_div,
  input logic         last_v,
  input logic [W+1:0] last_rem,
  input logic [W-1:0] last_div
);
  logic [LAT-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else begin
      hist[0] <= in_valid;
      for (int i = 1; i < LAT; i++) hist[i] <= hist[i-1];
    end
  end

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == hist[LAT-1]);

  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r5_rem_below_div: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fin_div != '0) |-> (remainder < fin_div));

  a_r5_partial_bound: assert property (@(posedge clk) disable iff (rst)
    (last_v && last_div != '0) |->
      ($signed(last_rem) >= -$signed({2'b00, last_div}) &&
       $signed(last_rem) <  $signed({2'b00, last_div})));

  a_r4_zero_div_ones: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fin_div == '0) |-> (quotient == '1));
endmodule

bind nr_div nr_div_chk #(.W(W), .LAT(LAT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .quotient (quotient),
  .remainder(remainder),
  .fin_div  (fin_div),
  .last_v   (v_p[NST]),
  .last_rem (rem_p[NST]),
  .last_div (d_p[NST])
);

// File: tb/nr_div_tb.sv
module nr_div_tb;
  localparam int W       = 16;
  localparam int BPS     = 4;
  localparam int OUT_REG = 1;
  localparam int LAT     = (W + BPS - 1) / BPS + OUT_REG;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor  = '0;
  logic         out_valid;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;

  nr_div #(.W(W), .BPS(BPS), .OUT_REG(OUT_REG)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dividend(dividend),
    .divisor(divisor), .out_valid(out_valid), .quotient(quotient),
    .remainder(remainder)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit done   = 0;

  logic         rv[64];
  logic [W-1:0] rq[64];
  logic [W-1:0] rr[64];
  logic [W-1:0] rd[64];
  string        rt[64];

  function automatic logic [W-1:0] ref_q(input logic [W-1:0] a, input logic [W-1:0] d);
    return (d == '0) ? '1 : a / d;
  endfunction

  function automatic logic [W-1:0] ref_r(input logic [W-1:0] a, input logic [W-1:0] d);
    return (d == '0) ? a : a % d;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // One cycle: check the output due now, then drive the next inputs.
  task automatic step(input bit r, input bit v, input logic [W-1:0] a,
                      input logic [W-1:0] d, input string tag);
    int j;
    @(negedge clk);
    if (rst) begin
      chk(out_valid == 1'b0, "R6", "out_valid during reset", {{(W-1){1'b0}}, out_valid}, '0);
    end else begin
      j = (n - LAT) % 64;
      if (n < LAT || !rv[j]) begin
        chk(out_valid == 1'b0, "R2", "out_valid low", {{(W-1){1'b0}}, out_valid}, '0);
      end else begin
        chk(out_valid == 1'b1, "R2", "out_valid high", {{(W-1){1'b0}}, out_valid}, 1);
        chk(quotient == rq[j], rt[j], "quotient", quotient, rq[j]);
        chk(remainder == rr[j], rt[j], "remainder", remainder, rr[j]);
        if (rd[j] != '0)
          chk(remainder < rd[j], "R5", "remainder below divisor", remainder, rd[j]);
      end
    end
    rst      = r;
    in_valid = v && !r;
    dividend = a;
    divisor  = d;
    j = n % 64;
    rv[j] = v && !r;
    rq[j] = ref_q(a, d);
    rr[j] = ref_r(a, d);
    rd[j] = d;
    rt[j] = (d == '0) ? "R4" : tag;
    n++;
  endtask

  function automatic logic [W-1:0] rnd_div();
    int sel;
    sel = $urandom_range(0, 9);
    if (sel == 0)      return '0;
    else if (sel <= 3) return W'($urandom_range(1, 15));
    else               return W'($urandom());
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      rv[i] = 1'b0; rq[i] = '0; rr[i] = '0; rd[i] = '0; rt[i] = "R1";
    end
    // Reset
    for (int i = 0; i < LAT + 2; i++) step(1, 0, '0, '0, "R6");
    // R7 directed extremes
    step(0, 1, '1, 16'd1, "R7");
    step(0, 1, '1, '1, "R7");
    step(0, 1, '0, 16'd5, "R7");
    step(0, 1, 16'd1234, '1, "R7");
    step(0, 1, 16'd7, 16'd7, "R7");
    step(0, 1, '1, 16'd2, "R7");
    step(0, 1, 16'h8000, 16'd3, "R1");
    step(0, 1, 16'd100, 16'd101, "R7");
    // R4 divide by zero
    step(0, 1, 16'd5, '0, "R4");
    step(0, 1, '1, '0, "R4");
    step(0, 1, '0, '0, "R4");
    // R3 back-to-back alternating divisors
    for (int i = 0; i < 16; i++)
      step(0, 1, W'(1000 + 37 * i), (i % 2 == 0) ? 16'd3 : 16'd997, "R3");
    // R2 gap pattern
    step(0, 1, 16'd50, 16'd6, "R2");
    step(0, 0, 16'd51, 16'd6, "R2");
    step(0, 0, 16'd52, 16'd6, "R2");
    step(0, 1, 16'd53, 16'd6, "R2");
    step(0, 1, 16'd54, 16'd7, "R2");
    step(0, 0, 16'd55, 16'd7, "R2");
    step(0, 1, 16'd56, 16'd8, "R2");
    // R1 random stream
    for (int i = 0; i < 2500; i++)
      step(0, ($urandom_range(0, 9) < 7), W'($urandom()), rnd_div(), "R1");
    // R6 reset with data in flight
    for (int i = 0; i < 3; i++) step(0, 1, W'($urandom()), W'($urandom()), "R1");
    for (int i = 0; i < LAT + 1; i++) step(1, 1, W'($urandom()), W'($urandom()), "R6");
    for (int i = 0; i < 300; i++)
      step(0, ($urandom_range(0, 1) == 1), W'($urandom()), rnd_div(), "R3");
    // Drain
    for (int i = 0; i < LAT + 2; i++) step(0, 0, '0, '0, "R2");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule